// File: doc/BRIEF.md
# Receive Endpoint Packet-Ready Handshake

This block keeps the status of a USB receive endpoint that holds up to two received packets in a double-buffered FIFO. The packet engine pulses a completion strobe with the byte count of each packet it writes. The block stores those lengths in arrival order and raises a packet-ready flag for the processor. It raises a FIFO-full flag when both buffers are occupied, and it refuses any further packet with a NAK indication.

The processor, or the unload path, reads the front packet out one byte per strobe. The buffer is released either by a software clear or by an automatic clear. The automatic clear fires on the last byte of a packet whose length equals the configured maximum, and only when auto-clear is enabled and the endpoint is not in high-bandwidth mode. If a release happens while both buffers are full, full drops first and packet-ready comes back one cycle later for the waiting packet.

Top module: `rxep_status`

## Requirements
- R1: After synchronous reset, pkt_ready, fifo_full and nak are all 0.
- R2: A packet completion strobe while no buffer is occupied makes pkt_ready 1 in the next cycle.
- R3: A packet completion strobe while one buffer is occupied and pkt_ready is 1 (with no release in that cycle) makes fifo_full 1 in the next cycle, and pkt_ready stays 1.
- R4: A packet completion strobe while fifo_full is 1 drives nak to 1 in that same cycle, and that packet is dropped: it never becomes ready.
- R5: A software clear while pkt_ready is 1 and fifo_full is 0 makes pkt_ready 0 in the next cycle.
- R6: A release while fifo_full is 1 makes fifo_full 0 and pkt_ready 0 in the next cycle, and pkt_ready 1 again in the cycle after that.
- R7: With auto_clr_en 1 and hb_mode 0, the unload strobe that reads the last byte of a front packet whose length equals max_size releases the buffer, so pkt_ready is 0 in the next cycle when fifo_full was 0.
- R8: A front packet shorter than max_size is never released automatically: pkt_ready stays 1 after all of its bytes and extra strobes are unloaded, until software clears it.
- R9: While hb_mode is 1, auto-clear has no effect, even on a maximum-size packet.
- R10: The unload byte count starts again from zero for each released buffer, and unload strobes while pkt_ready is 0 are not counted.
- R11: A release and a packet completion in the same cycle, with one buffer occupied, leave pkt_ready 1 and fifo_full 0 in the next cycle.
- R12: A software clear while pkt_ready is 0 has no effect on pkt_ready or fifo_full, including during the one-cycle re-arm gap of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_done | input | 1 | Packet completion strobe from the packet engine |
| pkt_len | input | LEN_W | Byte count of the completed packet |
| unload_byte | input | 1 | One byte of the front packet was read out |
| sw_clear | input | 1 | Software clear of packet-ready |
| auto_clr_en | input | 1 | Enables automatic clear on maximum-size packets |
| hb_mode | input | 1 | High-bandwidth mode; suppresses automatic clear |
| max_size | input | LEN_W | Maximum packet size of the endpoint |
| pkt_ready | output | 1 | A packet is waiting to be unloaded |
| fifo_full | output | 1 | Both buffers hold packets |
| nak | output | 1 | Current completion strobe is refused |

## Verification
The hardest situation to reach is the re-arm gap: both buffers must be full, the front packet must be released partway through its unload, and in the single cycle where pkt_ready is low the bench has to issue a stray software clear and stray unload strobes. The stimulus fills both buffers with maximum-size packets, unloads part of the first, clears it by software, then drives those strays in exactly the next cycle. It then proves that the second packet needs its full byte count before auto-clear fires. A reference model with a length queue tracks every cycle, so the drop of a third packet is also caught.

// File: rtl/rxep_pkg.sv
package rxep_pkg;

    localparam int NBUF = 2;

    typedef enum logic [1:0] {
        OCC_NONE = 2'd0,
        OCC_ONE  = 2'd1,
        OCC_TWO  = 2'd2
    } occ_e;

    function automatic logic is_last_byte(input int unsigned done_cnt,
                                          input int unsigned total);
        return (done_cnt + 1) == total;
    endfunction

endpackage

// File: rtl/rxep_buf_track.sv
module rxep_buf_track
    import rxep_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_done,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             rel,
    output logic             rdy,
    output logic             full,
    output logic             nak,
    output logic [LEN_W-1:0] front_len
);

    occ_e             occ_q, occ_d;
    logic             rdy_q, rdy_d;
    logic             rearm_q, rearm_d;
    logic             head_q;
    logic             tail;
    logic             accept;
    logic             pop;
    logic [LEN_W-1:0] slot_q [NBUF];

    assign nak    = pkt_done && (occ_q == OCC_TWO);
    assign accept = pkt_done && (occ_q != OCC_TWO);
    assign pop    = rel && rdy_q;
    assign tail   = head_q ^ (occ_q == OCC_ONE);

    always_comb begin
        occ_d = occ_q;
        case ({accept, pop})
            2'b10:   occ_d = occ_e'(occ_q + 2'd1);
            2'b01:   occ_d = occ_e'(occ_q - 2'd1);
            default: occ_d = occ_q;
        endcase
    end

    always_comb begin
        rdy_d   = rdy_q;
        rearm_d = 1'b0;
        if (rearm_q) begin
            rdy_d = 1'b1;
        end
        if (pop) begin
            if (occ_q == OCC_TWO) begin
                rdy_d   = 1'b0;
                rearm_d = 1'b1;
            end else begin
                rdy_d = accept;
            end
        end else if (accept && occ_q == OCC_NONE) begin
            rdy_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q   <= OCC_NONE;
            rdy_q   <= 1'b0;
            rearm_q <= 1'b0;
            head_q  <= 1'b0;
        end else begin
            occ_q   <= occ_d;
            rdy_q   <= rdy_d;
            rearm_q <= rearm_d;
            if (pop) head_q <= ~head_q;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) slot_q[tail] <= pkt_len;
    end

    assign rdy       = rdy_q;
    assign full      = (occ_q == OCC_TWO);
    assign front_len = slot_q[head_q];

    // R4
    nak_only_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        nak |-> full);

    // R2
    first_pkt_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && occ_q == OCC_NONE) |=> rdy);

    // R3
    full_has_owner_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> (rdy_q || rearm_q));

endmodule

// File: rtl/rxep_unload_ctr.sv
module rxep_unload_ctr
    import rxep_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unload_byte,
    input  logic             rdy,
    input  logic             rel,
    input  logic [LEN_W-1:0] front_len,
    input  logic [LEN_W-1:0] max_size,
    input  logic             auto_clr_en,
    input  logic             hb_mode,
    output logic             auto_rel
);

    logic [LEN_W-1:0] cnt_q;
    logic             counting;

    assign counting = unload_byte && rdy && (cnt_q < front_len);

    always_ff @(posedge clk) begin
        if (rst || rel) begin
            cnt_q <= '0;
        end else if (counting) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign auto_rel = auto_clr_en && !hb_mode && rdy && unload_byte
                   && (front_len == max_size)
                   && is_last_byte(32'(cnt_q), 32'(front_len));

    // R9
    no_auto_in_hb_chk: assert property (@(posedge clk) disable iff (rst)
        hb_mode |-> !auto_rel);

    // R8
    auto_only_max_chk: assert property (@(posedge clk) disable iff (rst)
        auto_rel |-> (front_len == max_size));

endmodule

// File: rtl/rxep_status.sv
module rxep_status
    import rxep_pkg::*;
#(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pkt_done,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             unload_byte,
    input  logic             sw_clear,
    input  logic             auto_clr_en,
    input  logic             hb_mode,
    input  logic [LEN_W-1:0] max_size,
    output logic             pkt_ready,
    output logic             fifo_full,
    output logic             nak
);

    logic             rdy;
    logic             full;
    logic             auto_rel;
    logic             rel;
    logic [LEN_W-1:0] front_len;

    assign rel = (sw_clear || auto_rel) && rdy;

    rxep_buf_track #(.LEN_W(LEN_W)) u_track (
        .clk       (clk),
        .rst       (rst),
        .pkt_done  (pkt_done),
        .pkt_len   (pkt_len),
        .rel       (rel),
        .rdy       (rdy),
        .full      (full),
        .nak       (nak),
        .front_len (front_len)
    );

    rxep_unload_ctr #(.LEN_W(LEN_W)) u_unload (
        .clk         (clk),
        .rst         (rst),
        .unload_byte (unload_byte),
        .rdy         (rdy),
        .rel         (rel),
        .front_len   (front_len),
        .max_size    (max_size),
        .auto_clr_en (auto_clr_en),
        .hb_mode     (hb_mode),
        .auto_rel    (auto_rel)
    );

    assign pkt_ready = rdy;
    assign fifo_full = full;

    // R6
    rearm_after_full_chk: assert property (@(posedge clk) disable iff (rst)
        (full && rel) |=> (!fifo_full && !pkt_ready) ##1 pkt_ready);

    // R5
    single_release_chk: assert property (@(posedge clk) disable iff (rst)
        (rel && !full && !pkt_done) |=> !pkt_ready);

endmodule

// File: tb/rxep_status_tb.sv
module rxep_status_tb;

    localparam int LEN_W = 11;
    localparam int MAXP  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pkt_done = 1'b0;
    logic [LEN_W-1:0] pkt_len = '0;
    logic             unload_byte = 1'b0;
    logic             sw_clear = 1'b0;
    logic             auto_clr_en = 1'b0;
    logic             hb_mode = 1'b0;
    logic [LEN_W-1:0] max_size = LEN_W'(MAXP);
    logic             pkt_ready, fifo_full, nak;

    int checks = 0;
    int errors = 0;

    int q[$];
    bit m_rdy = 0;
    bit m_rearm = 0;
    int m_cnt = 0;

    always #4 clk = ~clk;

    rxep_status #(.LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst(rst), .pkt_done(pkt_done), .pkt_len(pkt_len),
        .unload_byte(unload_byte), .sw_clear(sw_clear),
        .auto_clr_en(auto_clr_en), .hb_mode(hb_mode), .max_size(max_size),
        .pkt_ready(pkt_ready), .fifo_full(fifo_full), .nak(nak)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, check nak, advance model, compare at next negedge
    task automatic cyc(input bit pd, input int len, input bit ub, input bit sw, input string tag);
        bit accept, rel, autop;
        int n;
        bit nrdy, nrearm;
        pkt_done    = pd;
        pkt_len     = LEN_W'(len);
        unload_byte = ub;
        sw_clear    = sw;
        #1;
        n = q.size();
        check(tag, "nak", int'(nak), int'(pd && n == 2));
        accept = pd && n < 2;
        autop  = auto_clr_en && !hb_mode && m_rdy && ub && n > 0
              && q[0] == MAXP && (m_cnt + 1 == q[0]);
        rel    = m_rdy && (sw || autop);
        nrdy   = m_rdy;
        nrearm = 0;
        if (m_rearm) nrdy = 1;
        if (rel) begin
            if (n == 2) begin nrdy = 0; nrearm = 1; end
            else nrdy = accept;
        end else if (accept && n == 0) begin
            nrdy = 1;
        end
        if (rel) m_cnt = 0;
        else if (ub && m_rdy && n > 0 && m_cnt < q[0]) m_cnt++;
        @(posedge clk);
        if (rel) void'(q.pop_front());
        if (accept) q.push_back(len);
        m_rdy   = nrdy;
        m_rearm = nrearm;
        @(negedge clk);
        check(tag, "pkt_ready", int'(pkt_ready), int'(m_rdy));
        check(tag, "fifo_full", int'(fifo_full), int'(q.size() == 2));
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "pkt_ready", int'(pkt_ready), 0);
        check("R1", "fifo_full", int'(fifo_full), 0);
        check("R1", "nak", int'(nak), 0);

        // R2 first packet, R3 second packet, R4 third refused
        cyc(1, MAXP, 0, 0, "R2");
        check("R2", "ready after first", int'(pkt_ready), 1);
        cyc(1, 5, 0, 0, "R3");
        check("R3", "full after second", int'(fifo_full), 1);
        cyc(1, 3, 0, 0, "R4");
        check("R4", "still full", int'(fifo_full), 1);

        // R7 + R6: auto release of max packet while full
        auto_clr_en = 1'b1;
        for (int i = 0; i < MAXP - 1; i++) cyc(0, 0, 1, 0, "R7");
        check("R7", "ready before last byte", int'(pkt_ready), 1);
        cyc(0, 0, 1, 0, "R6");
        check("R6", "full dropped", int'(fifo_full), 0);
        check("R6", "ready gap", int'(pkt_ready), 0);
        idle("R6");
        check("R6", "ready rearmed", int'(pkt_ready), 1);

        // R8 short packet not auto released
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, "R8");
        check("R8", "short stays ready", int'(pkt_ready), 1);

        // R5 software clear; R4 third packet never appears
        cyc(0, 0, 0, 1, "R5");
        check("R5", "cleared", int'(pkt_ready), 0);
        idle("R4");
        check("R4", "dropped packet absent", int'(pkt_ready), 0);

        // R12 strays while empty
        cyc(0, 0, 1, 1, "R12");
        check("R12", "empty clear no effect", int'(pkt_ready), 0);

        // R9 high-bandwidth suppresses auto clear
        hb_mode = 1'b1;
        cyc(1, MAXP, 0, 0, "R9");
        for (int i = 0; i < MAXP; i++) cyc(0, 0, 1, 0, "R9");
        check("R9", "no auto in hb", int'(pkt_ready), 1);
        cyc(0, 0, 0, 1, "R9");
        hb_mode = 1'b0;

        // R10 count restarts per buffer; gap strays ignored (R12)
        cyc(1, MAXP, 0, 0, "R10");
        cyc(1, MAXP, 0, 0, "R10");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, "R10");
        cyc(0, 0, 0, 1, "R10");
        check("R10", "gap after clear", int'(pkt_ready), 0);
        cyc(0, 0, 1, 1, "R12");
        check("R12", "rearm despite stray clear", int'(pkt_ready), 1);
        check("R12", "single buffer left", int'(fifo_full), 0);
        for (int i = 0; i < MAXP - 1; i++) cyc(0, 0, 1, 0, "R10");
        check("R10", "needs full count", int'(pkt_ready), 1);
        cyc(0, 0, 1, 0, "R10");
        check("R10", "auto after full count", int'(pkt_ready), 0);

        // R11 release and arrival together
        cyc(1, 4, 0, 0, "R11");
        cyc(1, 6, 0, 1, "R11");
        check("R11", "ready kept", int'(pkt_ready), 1);
        check("R11", "not full", int'(fifo_full), 0);
        cyc(0, 0, 0, 1, "R11");
        check("R11", "released", int'(pkt_ready), 0);
        idle("R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule